// File: doc/BRIEF.md
# Multi-Converter Serial Word Loader

This block sits on the host side of a group of serial-input digital-to-analog converters. It takes one 16-bit word per converter, all at once, together with a start pulse. It then produces the serial clock, the data line, one active-low input-register enable per converter, one shared active-low update strobe and an active-low clear line. A start while the block is busy has no effect. The block raises `busy` while it works and pulses `done` when the new codes have been strobed into every converter.

Two wiring schemes are supported, and `topo_i` picks one for each transfer. In chained mode the converters pass data from one to the next, and all enables fall together. One continuous frame of 16×N bits is sent, beginning with the word for the converter farthest from the host. In select mode the converters share clock and data. Each converter is enabled in turn for its own 16 bits, from the highest index down to index 0. After either transfer, one shared strobe with one clock pulse moves every input register into its output latch at the same moment. Every phase lasts `HALF_TICKS` system cycles, and the clear pulse lasts `CLR_TICKS` cycles. With a 50 MHz system clock, the defaults give at least 50 ns of setup, high time and low time, and a clear pulse of 200 ns.

Top module: `dac_chain_loader`

## Requirements
- R1: In chained mode (`topo_i`=0), every enable line is low for the whole frame. Each converter sees exactly 16×N rising serial-clock edges while enabled. Word k (bits `words_i[16k+15:16k]`, converter 0 nearest the host) ends up in converter k, and the farthest word is sent first.
- R2: In select mode (`topo_i`=1), at most one enable line is low at any time. The lines are taken from index N-1 down to 0, and each converter sees exactly 16 rising edges and receives its own word.
- R3: Each word is sent most significant bit first, one bit for each rising edge of `sclk_o`.
- R4: Every low phase of `sclk_o` lasts exactly HALF_TICKS cycles, and every high phase lasts at least HALF_TICKS cycles. `sclk_o` rests high.
- R5: `sdi_o` changes only in the cycle where `sclk_o` falls, which gives HALF_TICKS cycles of setup and hold around each rising edge.
- R6: An enable line is low for at least HALF_TICKS cycles before the first falling clock edge it covers. Enable lines change only when `sclk_o` has been high for at least HALF_TICKS cycles.
- R7: After the last data bit, `update_n_o` goes low with every enable high. It stays low for 3×HALF_TICKS cycles and encloses exactly one rising clock edge.
- R8: `done_o` is a one-cycle pulse in the cycle after `update_n_o` rises, and `busy_o` falls in that same cycle. `busy_o` is high from the cycle after an accepted start.
- R9: A start while busy is ignored: the transfer in progress keeps its words and its edge count, and no second transfer follows.
- R10: `clear_i` while idle drives `clr_n_o` low for exactly CLR_TICKS cycles with enables, strobe and clock inactive. This resets every converter register to 0000h, and no `done_o` pulse follows.
- R11: After reset, `sclk_o`=1, all enables are 1, `update_n_o`=1, `clr_n_o`=1, `sdi_o`=0, `busy_o`=0 and `done_o`=0.
- R12: When `start_i` and `clear_i` arrive in the same idle cycle, the transfer starts and the clear is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a transfer (one-cycle pulse) |
| clear_i | input | 1 | Request a clear pulse |
| topo_i | input | 1 | 0 = chained, 1 = select mode |
| words_i | input | N_DEV*WORD_W | One word per converter, converter k at bits 16k+15:16k |
| sclk_o | output | 1 | Serial clock to all converters |
| sdi_o | output | 1 | Serial data to the first or to every converter |
| shift_en_n_o | output | N_DEV | Active-low input-register enables |
| update_n_o | output | 1 | Shared active-low output-latch strobe |
| clr_n_o | output | 1 | Active-low clear to all converters |
| busy_o | output | 1 | Transfer or clear in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a start that arrives in the middle of a chained frame. If it were wrongly accepted, the data would be mixed so that most converters still look plausible. The bench pulses start with different words partway through a frame. It then checks the per-converter edge counts and the latched words, using a bench model of a chain of shift registers and latches that the outputs drive. The same model shows a swapped chain order or a dropped bit as a wrong word in a specific converter.

// File: rtl/dacld_pkg.sv
package dacld_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CLEAR, ST_SETUP, ST_LOW, ST_HIGH,
    ST_LSETUP, ST_LLOW, ST_LHIGH, ST_DONE
  } ld_state_t;

  typedef enum logic {
    TOPO_CHAIN  = 1'b0,
    TOPO_SELECT = 1'b1
  } topo_t;
endpackage

// File: rtl/dacld_phase_timer.sv
module dacld_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)               cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/dacld_word_bank.sv
module dacld_word_bank #(
  parameter int N_DEV  = 4,
  parameter int WORD_W = 16,
  parameter int DEV_W  = 2,
  parameter int BIT_W  = 4
) (
  input  logic                    clk_i,
  input  logic                    capture_i,
  input  logic [N_DEV*WORD_W-1:0] words_i,
  input  logic [DEV_W-1:0]        dev_i,
  input  logic [BIT_W-1:0]        bit_i,
  output logic                    bit_o
);
  logic [WORD_W-1:0] mem [N_DEV];

  always_ff @(posedge clk_i) begin
    if (capture_i) begin
      for (int k = 0; k < N_DEV; k++) mem[k] <= words_i[k*WORD_W +: WORD_W];
    end
  end

  always_comb begin
    bit_o = 1'b0;
    if (int'(dev_i) < N_DEV && int'(bit_i) < WORD_W) bit_o = mem[dev_i][bit_i];
  end
endmodule

// File: rtl/dacld_enable_dec.sv
module dacld_enable_dec
  import dacld_pkg::*;
#(
  parameter int N_DEV = 4,
  parameter int DEV_W = 2
) (
  input  logic             active_i,
  input  topo_t            topo_i,
  input  logic [DEV_W-1:0] dev_i,
  output logic [N_DEV-1:0] sel_n_o
);
  for (genvar g = 0; g < N_DEV; g++) begin : g_line
    assign sel_n_o[g] = !(active_i && (topo_i == TOPO_CHAIN || dev_i == DEV_W'(g)));
  end
endmodule

// File: rtl/dac_chain_loader.sv
module dac_chain_loader
  import dacld_pkg::*;
#(
  parameter int N_DEV      = 4,
  parameter int WORD_W     = 16,
  parameter int HALF_TICKS = 3,
  parameter int CLR_TICKS  = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic                    start_i,
  input  logic                    clear_i,
  input  logic                    topo_i,
  input  logic [N_DEV*WORD_W-1:0] words_i,
  output logic                    sclk_o,
  output logic                    sdi_o,
  output logic [N_DEV-1:0]        shift_en_n_o,
  output logic                    update_n_o,
  output logic                    clr_n_o,
  output logic                    busy_o,
  output logic                    done_o
);
  localparam int DEV_W = (N_DEV > 1) ? $clog2(N_DEV) : 1;
  localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam int TMAX  = (HALF_TICKS > CLR_TICKS) ? HALF_TICKS : CLR_TICKS;
  localparam int CNT_W = $clog2(TMAX + 1);

  ld_state_t        state_q, state_d;
  topo_t            topo_q, topo_d;
  logic [DEV_W-1:0] dev_q, dev_d, rd_dev;
  logic [BIT_W-1:0] bit_q, bit_d, rd_bit;
  logic             a0on_q, a0on_d;
  logic             sclk_d, sdi_d, a1n_d, clrn_d, busy_d, done_d;
  logic             tmr_load, tmr_exp, capture, bank_bit;
  logic [CNT_W-1:0] tmr_val;
  logic [N_DEV-1:0] sel_n;

  dacld_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(tmr_load),
    .load_val_i(tmr_val), .expired_o(tmr_exp)
  );

  dacld_word_bank #(.N_DEV(N_DEV), .WORD_W(WORD_W), .DEV_W(DEV_W), .BIT_W(BIT_W)) u_bank (
    .clk_i(clk_i), .capture_i(capture), .words_i(words_i),
    .dev_i(rd_dev), .bit_i(rd_bit), .bit_o(bank_bit)
  );

  dacld_enable_dec #(.N_DEV(N_DEV), .DEV_W(DEV_W)) u_dec (
    .active_i(a0on_d), .topo_i(topo_d), .dev_i(dev_d), .sel_n_o(sel_n)
  );

  // index of the bit presented next
  always_comb begin
    rd_dev = dev_q;
    rd_bit = bit_q;
    if (state_q == ST_HIGH) begin
      if (bit_q != '0) begin
        rd_bit = bit_q - BIT_W'(1);
      end else begin
        rd_dev = dev_q - DEV_W'(1);
        rd_bit = BIT_W'(WORD_W - 1);
      end
    end
  end

  always_comb begin
    state_d  = state_q;
    topo_d   = topo_q;
    dev_d    = dev_q;
    bit_d    = bit_q;
    a0on_d   = a0on_q;
    sclk_d   = sclk_o;
    sdi_d    = sdi_o;
    a1n_d    = update_n_o;
    clrn_d   = clr_n_o;
    busy_d   = busy_o;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = CNT_W'(HALF_TICKS - 1);
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d  = ST_SETUP;
          topo_d   = topo_t'(topo_i);
          dev_d    = DEV_W'(N_DEV - 1);
          bit_d    = BIT_W'(WORD_W - 1);
          a0on_d   = 1'b1;
          busy_d   = 1'b1;
          capture  = 1'b1;
          tmr_load = 1'b1;
        end else if (clear_i) begin
          state_d  = ST_CLEAR;
          clrn_d   = 1'b0;
          busy_d   = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(CLR_TICKS - 1);
        end
      end
      ST_CLEAR: if (tmr_exp) begin
        clrn_d  = 1'b1;
        busy_d  = 1'b0;
        state_d = ST_IDLE;
      end
      ST_SETUP: if (tmr_exp) begin
        sclk_d   = 1'b0;
        sdi_d    = bank_bit;
        state_d  = ST_LOW;
        tmr_load = 1'b1;
      end
      ST_LOW: if (tmr_exp) begin
        sclk_d   = 1'b1;
        state_d  = ST_HIGH;
        tmr_load = 1'b1;
      end
      ST_HIGH: if (tmr_exp) begin
        tmr_load = 1'b1;
        if (bit_q != '0 || (dev_q != '0 && topo_q == TOPO_CHAIN)) begin
          dev_d   = rd_dev;
          bit_d   = rd_bit;
          sclk_d  = 1'b0;
          sdi_d   = bank_bit;
          state_d = ST_LOW;
        end else if (dev_q != '0) begin
          dev_d   = rd_dev;
          bit_d   = rd_bit;
          state_d = ST_SETUP;
        end else begin
          a0on_d  = 1'b0;
          a1n_d   = 1'b0;
          state_d = ST_LSETUP;
        end
      end
      ST_LSETUP: if (tmr_exp) begin
        sclk_d   = 1'b0;
        state_d  = ST_LLOW;
        tmr_load = 1'b1;
      end
      ST_LLOW: if (tmr_exp) begin
        sclk_d   = 1'b1;
        state_d  = ST_LHIGH;
        tmr_load = 1'b1;
      end
      ST_LHIGH: if (tmr_exp) begin
        a1n_d   = 1'b1;
        state_d = ST_DONE;
      end
      ST_DONE: begin
        done_d  = 1'b1;
        busy_d  = 1'b0;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q      <= ST_IDLE;
      topo_q       <= TOPO_CHAIN;
      dev_q        <= '0;
      bit_q        <= '0;
      a0on_q       <= 1'b0;
      sclk_o       <= 1'b1;
      sdi_o        <= 1'b0;
      shift_en_n_o <= '1;
      update_n_o   <= 1'b1;
      clr_n_o      <= 1'b1;
      busy_o       <= 1'b0;
      done_o       <= 1'b0;
    end else begin
      state_q      <= state_d;
      topo_q       <= topo_d;
      dev_q        <= dev_d;
      bit_q        <= bit_d;
      a0on_q       <= a0on_d;
      sclk_o       <= sclk_d;
      sdi_o        <= sdi_d;
      shift_en_n_o <= sel_n;
      update_n_o   <= a1n_d;
      clr_n_o      <= clrn_d;
      busy_o       <= busy_d;
      done_o       <= done_d;
    end
  end

  AST_STROBE_ENABLES_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
    !update_n_o |-> &shift_en_n_o); // R7
  AST_SELECT_ONE_LINE: assert property (@(posedge clk_i) disable iff (rst_i)
    (topo_q == TOPO_SELECT && busy_o) |-> $onehot0(~shift_en_n_o)); // R2
  AST_SDI_ON_FALL: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(sdi_o) |-> $fell(sclk_o)); // R5
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(update_n_o) |=> (done_o && !busy_o)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o); // R8
  AST_CLR_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
    !clr_n_o |-> (&shift_en_n_o && update_n_o && sclk_o)); // R10
endmodule

// File: tb/tb_dac_chain_loader.sv
module tb_dac_chain_loader;
  localparam int N  = 4;
  localparam int W  = 16;
  localparam int HT = 3;
  localparam int CT = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, clear = 1'b0, topo = 1'b0;
  logic [N*W-1:0] words = '0;
  logic sclk, sdi, upd_n, clr_n, busy, done;
  logic [N-1:0] en_n;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  dac_chain_loader #(.N_DEV(N), .WORD_W(W), .HALF_TICKS(HT), .CLR_TICKS(CT)) dut (
    .clk_i(clk), .rst_i(rst), .start_i(start), .clear_i(clear), .topo_i(topo),
    .words_i(words), .sclk_o(sclk), .sdi_o(sdi), .shift_en_n_o(en_n),
    .update_n_o(upd_n), .clr_n_o(clr_n), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_edges(input logic t);
    return t ? W : W * N;
  endfunction

  // converter model driven by the outputs
  logic [W-1:0] sh [N];
  logic [W-1:0] lat [N];
  int  edges [N];
  logic p_sclk, p_sdi, p_upd, p_clr, p_done_pend;
  logic [N-1:0] p_en;
  int  sclk_run, en_run, clr_run, next_sel, upd_edges, clr_pulses;

  always @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin sh[i] = '0; lat[i] = '0; edges[i] = 0; end
      p_sclk = sclk; p_sdi = sdi; p_upd = upd_n; p_clr = clr_n; p_en = en_n;
      p_done_pend = 1'b0; sclk_run = 0; en_run = 0; clr_run = 0; upd_edges = 0;
      clr_pulses = 0; next_sel = N - 1;
    end else begin
      if (done) begin
        chk(p_done_pend, "R8 done without strobe end", 1, 0);
        chk(!busy, "R8 busy low with done", busy, 0);
      end else if (p_done_pend) begin
        chk(1'b0, "R8 done one cycle after strobe", 0, 1);
      end
      p_done_pend = (!p_upd && upd_n);
      if (sdi != p_sdi) chk(p_sclk && !sclk, "R5 sdi change off falling edge", sclk, 0);
      if (en_n != p_en) begin
        chk(sclk && sclk_run >= HT, "R6 enable change while clock high", sclk_run, HT);
        for (int i = 0; i < N; i++)
          if (p_en[i] && !en_n[i] && topo) begin
            chk(i == next_sel, "R2 select order", i, next_sel);
            next_sel--;
          end
        if (topo) chk($countones(~en_n) <= 1, "R2 one line low", ~en_n, 0);
        else chk(&en_n || en_n == '0, "R1 lines move together", en_n, 0);
        en_run = 0;
      end else en_run++;
      if (sclk != p_sclk) begin
        if (!p_sclk) chk(sclk_run == HT, "R4 low phase length", sclk_run, HT);
        else chk(sclk_run >= HT, "R4 high phase length", sclk_run, HT);
        if (!sclk && !(&en_n)) chk(en_run >= HT, "R6 enable setup", en_run, HT);
        sclk_run = 1;
      end else sclk_run++;
      if (!p_sclk && sclk) begin
        if (!upd_n) begin
          chk(&en_n, "R7 enables high during strobe", en_n, '1);
          upd_edges++;
          for (int i = 0; i < N; i++) lat[i] = sh[i];
        end
        for (int i = N - 1; i >= 0; i--)
          if (!en_n[i]) begin
            sh[i] = {sh[i][W-2:0], (topo || i == 0) ? sdi : sh[i-1][W-1]};
            edges[i]++;
          end
      end
      if (!clr_n) begin
        chk(&en_n && upd_n, "R10 quiet during clear", {en_n, upd_n}, '1);
        for (int i = 0; i < N; i++) begin sh[i] = '0; lat[i] = '0; end
        clr_run++;
      end else if (!p_clr) begin
        chk(clr_run == CT, "R10 clear pulse width", clr_run, CT);
        clr_pulses++;
        clr_run = 0;
      end
      p_sclk = sclk; p_sdi = sdi; p_upd = upd_n; p_clr = clr_n; p_en = en_n;
    end
  end

  task automatic kick(input logic t, input logic [N*W-1:0] w, input bit with_clear);
    @(negedge clk);
    for (int i = 0; i < N; i++) edges[i] = 0;
    upd_edges = 0; next_sel = N - 1;
    topo = t; words = w; start = 1'b1; clear = with_clear;
    @(negedge clk);
    start = 1'b0; clear = 1'b0;
  endtask

  task automatic finish_and_check(input logic t, input logic [N*W-1:0] w, input string tag);
    chk(busy, "R8 busy after start", busy, 1);
    @(posedge done);
    @(negedge clk);
    chk(upd_edges == 1, "R7 one edge under strobe", upd_edges, 1);
    for (int i = 0; i < N; i++) begin
      chk(lat[i] == w[i*W +: W], {tag, " word in converter"}, lat[i], w[i*W +: W]);
      chk(edges[i] == exp_edges(t), {tag, " edge count"}, edges[i], exp_edges(t));
    end
  endtask

  task automatic load(input logic t, input logic [N*W-1:0] w);
    kick(t, w, 1'b0);
    finish_and_check(t, w, t ? "R2 R3" : "R1 R3");
    repeat (5) @(negedge clk);
  endtask

  function automatic logic [N*W-1:0] rnd_words();
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = W'($urandom);
    return v;
  endfunction

  initial begin
    logic [N*W-1:0] w0;
    void'($urandom(32'd7));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sclk && &en_n && upd_n && clr_n && !sdi && !busy && !done, "R11 reset state",
        {sclk, en_n, upd_n, clr_n, sdi, busy, done}, {1'b1, {N{1'b1}}, 3'b110, 2'b00});
    repeat (5) @(negedge clk);

    load(1'b0, {16'h8000, 16'h7FFF, 16'h0001, 16'hFFFF});
    load(1'b1, {16'h0000, 16'hFFFF, 16'h8000, 16'h7FFF});
    for (int r = 0; r < 8; r++) load(1'(r % 2), rnd_words());

    // R9: start in the middle of a chained frame
    w0 = rnd_words();
    kick(1'b0, w0, 1'b0);
    repeat (60) @(negedge clk);
    words = ~w0; topo = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    topo = 1'b0;
    finish_and_check(1'b0, w0, "R9");
    repeat (40) @(negedge clk);
    chk(!busy && sclk, "R9 no second transfer", busy, 0);

    // R10: clear while idle resets all converter registers
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    repeat (CT + 5) @(negedge clk);
    chk(clr_pulses == 1, "R10 one clear pulse", clr_pulses, 1);
    for (int i = 0; i < N; i++) chk(lat[i] == '0, "R10 latch cleared", lat[i], 0);
    chk(!busy, "R10 idle after clear", busy, 0);

    // R12: start and clear together
    w0 = rnd_words();
    kick(1'b1, w0, 1'b1);
    finish_and_check(1'b1, w0, "R12");
    chk(clr_pulses == 1, "R12 clear dropped", clr_pulses, 1);

    repeat (10) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule